// File: doc/BRIEF.md
# Directory-Coherent Node Cache Controller

This block is the cache controller of one processing node in a multiprocessor that keeps caches coherent through a home directory rather than a shared bus. It owns a small direct-mapped write-back cache of one-word lines. Each line is Invalid, Shared (readable) or Exclusive (sole, writable, dirty copy). Processor loads and stores are served from the cache when they hit. A miss stalls the processor and sends an addressed request to the home. The access completes only when the home's data reply comes back.

The home can also address this node with three coherence commands. An invalidate removes a shared copy. A fetch asks the owner of an Exclusive line to return its data and keep a Shared copy. A fetch-and-invalidate asks for the data and drops the copy. Both fetch forms answer with a write-back message.

All traffic uses two valid/ready message ports, one outgoing and one incoming. Each message carries a 3-bit type code, an address and a data word, and outgoing messages also carry this node's number. Incoming messages are taken one at a time in arrival order. Only one miss may be outstanding.

Top module: `dir_node_cache`

## Requirements
- R1: After reset every line is Invalid, `out_valid` and `cpu_ack` are 0 and `in_ready` is 1, so the first access to any index misses.
- R2: A read that finds its line Shared or Exclusive with a matching tag raises `cpu_ack` for one cycle, one cycle after the request is sampled, with the line's data on `cpu_rdata` and no outgoing message.
- R3: A read miss sends type 0 (read request), and a write to a line not held Exclusive sends type 1 (write request). Each carries the access address and `out_src` equal to the node number, and its fields stay unchanged while `out_ready` is low.
- R4: A missing access is not acknowledged until a type 5 reply with the same address is accepted. `cpu_ack` follows one cycle later. The line then becomes Shared after a read with `cpu_rdata` equal to the reply data, or Exclusive after a write holding the written data, with `cpu_rdata` equal to that data.
- R5: A write to a line held Exclusive with a matching tag updates the line locally, sends no message and acknowledges one cycle after it is sampled.
- R6: A type 2 invalidate whose address matches a Shared line makes that line Invalid, so the next read of that address misses.
- R7: A type 3 fetch whose address matches an Exclusive line sends a type 6 write-back with that address and the line's data. The line becomes Shared: later reads hit, and a later write sends a type 1 request.
- R8: A type 4 fetch-and-invalidate whose address matches an Exclusive line sends a type 6 write-back with the address and data, and the line becomes Invalid.
- R9: A miss whose index holds an Exclusive line with a different tag first sends a type 6 write-back of the victim (victim address and data). Only after that message it sends the request for the new address.
- R10: An invalidate, fetch or fetch-and-invalidate whose address does not match a held line sends nothing and leaves the line's contents unchanged.
- R11: While an outgoing message waits for `out_ready`, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until acknowledged |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Access word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | One-cycle access completion |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_ack` |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Network accepts outgoing message |
| out_type | output | 3 | Outgoing type (0 read req, 1 write req, 6 write-back) |
| out_src | output | NODE_W | This node's number |
| out_addr | output | ADDR_W | Outgoing message address |
| out_data | output | DATA_W | Outgoing message data |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Controller takes the incoming message this cycle |
| in_type | input | 3 | Incoming type (2 invalidate, 3 fetch, 4 fetch-invalidate, 5 reply) |
| in_addr | input | ADDR_W | Incoming message address |
| in_data | input | DATA_W | Incoming data (reply) |

## Verification
A hit is due one cycle after the edge that samples the request, so the bench raises the request at a falling edge and reads `cpu_ack` at the next falling edge. A miss request appears two edges after sampling, or later when a victim write-back must leave first. A write-back caused by a fetch appears the edge after the fetch is taken. The acknowledgement of a miss appears the edge after the reply is taken. The bench waits for outgoing messages in bounded loops and releases each one itself. It drives every incoming message from a falling edge, holds it until `in_ready` is seen high and drops it after the accepting edge. It then checks the outputs at that same falling edge, which is the first cycle the result is due.

// File: rtl/dnc_pkg.sv
package dnc_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2
   } line_st_t;

   typedef enum logic [2:0] {
      MT_RDREQ  = 3'd0,
      MT_WRREQ  = 3'd1,
      MT_INVAL  = 3'd2,
      MT_FETCH  = 3'd3,
      MT_FETINV = 3'd4,
      MT_REPLY  = 3'd5,
      MT_WBACK  = 3'd6
   } msg_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2,
      SQ_ACK  = 2'd3
   } seq_st_t;

endpackage

// File: rtl/dnc_line_array.sv
module dnc_line_array
   import dnc_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  line_st_t          wr_st,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_dat,
   input  logic [IDX_W-1:0]  ra_idx,
   output line_st_t          ra_st,
   output logic [TAG_W-1:0]  ra_tag,
   output logic [DATA_W-1:0] ra_dat,
   input  logic [IDX_W-1:0]  rb_idx,
   output line_st_t          rb_st,
   output logic [TAG_W-1:0]  rb_tag,
   output logic [DATA_W-1:0] rb_dat
);

   localparam int LINES = 2 ** IDX_W;

   line_st_t          st_all  [LINES];
   logic [TAG_W-1:0]  tag_all [LINES];
   logic [DATA_W-1:0] dat_all [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_t          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] dat_r;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r  <= LS_INV;
            tag_r <= '0;
            dat_r <= '0;
         end else if (sel) begin
            st_r  <= wr_st;
            tag_r <= wr_tag;
            dat_r <= wr_dat;
         end
      end

      assign st_all[g]  = st_r;
      assign tag_all[g] = tag_r;
      assign dat_all[g] = dat_r;
   end

   assign ra_st  = st_all[ra_idx];
   assign ra_tag = tag_all[ra_idx];
   assign ra_dat = dat_all[ra_idx];
   assign rb_st  = st_all[rb_idx];
   assign rb_tag = tag_all[rb_idx];
   assign rb_dat = dat_all[rb_idx];

endmodule

// File: rtl/dnc_msg_reg.sv
module dnc_msg_reg
   import dnc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  msg_t              ld_type,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              out_ready,
   output logic              out_valid,
   output msg_t              out_type,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_type  <= MT_WBACK;
         out_addr  <= '0;
         out_data  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_type  <= ld_type;
         out_addr  <= ld_addr;
         out_data  <= ld_data;
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R3: a pending message keeps its contents until it is taken
   p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_type)
                                     && $stable(out_addr) && $stable(out_data)));

   // R11: the sequencer never overwrites a message still waiting
   p_load_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !out_valid);

endmodule

// File: rtl/dnc_seq.sv
module dnc_seq
   import dnc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              in_valid,
   input  logic [2:0]        in_type,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              ob_valid,
   output logic              ob_load,
   output msg_t              ob_type,
   output logic [ADDR_W-1:0] ob_addr,
   output logic [DATA_W-1:0] ob_data,
   output logic              lw_en,
   output logic [IDX_W-1:0]  lw_idx,
   output line_st_t          lw_st,
   output logic [ADDR_W-IDX_W-1:0] lw_tag,
   output logic [DATA_W-1:0] lw_dat,
   output logic [IDX_W-1:0]  ra_idx,
   input  line_st_t          ra_st,
   input  logic [ADDR_W-IDX_W-1:0] ra_tag,
   input  logic [DATA_W-1:0] ra_dat,
   output logic [IDX_W-1:0]  rb_idx,
   input  line_st_t          rb_st,
   input  logic [ADDR_W-IDX_W-1:0] rb_tag,
   input  logic [DATA_W-1:0] rb_dat
);

   localparam int TAG_W = ADDR_W - IDX_W;

   seq_st_t           st_q, st_n;
   logic [DATA_W-1:0] rd_q, rd_n;
   logic              rd_load;
   logic              coh_go;

   logic [IDX_W-1:0]  cidx, iidx;
   logic [TAG_W-1:0]  ctag, itag;
   logic              a_match, b_match, in_fire, reply_hit;
   msg_t              in_msg;

   assign cidx    = cpu_addr[IDX_W-1:0];
   assign ctag    = cpu_addr[ADDR_W-1:IDX_W];
   assign iidx    = in_addr[IDX_W-1:0];
   assign itag    = in_addr[ADDR_W-1:IDX_W];
   assign ra_idx  = cidx;
   assign rb_idx  = iidx;
   assign in_msg  = msg_t'(in_type);

   assign a_match = (ra_st != LS_INV) && (ra_tag == ctag);
   assign b_match = (rb_st != LS_INV) && (rb_tag == itag);

   assign in_ready  = ((st_q == SQ_IDLE) || (st_q == SQ_WAIT)) && !ob_valid;
   assign in_fire   = in_valid && in_ready;
   assign reply_hit = (in_msg == MT_REPLY) && (in_addr == cpu_addr);

   always_comb begin
      st_n    = st_q;
      lw_en   = 1'b0;
      lw_idx  = cidx;
      lw_st   = LS_INV;
      lw_tag  = ctag;
      lw_dat  = cpu_wdata;
      ob_load = 1'b0;
      ob_type = MT_WBACK;
      ob_addr = cpu_addr;
      ob_data = '0;
      rd_load = 1'b0;
      rd_n    = ra_dat;
      coh_go  = 1'b0;

      case (st_q)
         SQ_IDLE: begin
            if (in_fire) begin
               coh_go = 1'b1;
            end else if (cpu_req && !ob_valid) begin
               if (a_match && !cpu_we) begin
                  rd_load = 1'b1;
                  st_n    = SQ_ACK;
               end else if (a_match && cpu_we && (ra_st == LS_EXC)) begin
                  lw_en   = 1'b1;
                  lw_st   = LS_EXC;
                  rd_load = 1'b1;
                  rd_n    = cpu_wdata;
                  st_n    = SQ_ACK;
               end else begin
                  if ((ra_st == LS_EXC) && (ra_tag != ctag)) begin
                     ob_load = 1'b1;
                     ob_type = MT_WBACK;
                     ob_addr = {ra_tag, cidx};
                     ob_data = ra_dat;
                     lw_en   = 1'b1;
                     lw_st   = LS_INV;
                     lw_tag  = ra_tag;
                     lw_dat  = ra_dat;
                  end
                  st_n = SQ_REQ;
               end
            end
         end
         SQ_REQ: begin
            if (!ob_valid) begin
               ob_load = 1'b1;
               ob_type = cpu_we ? MT_WRREQ : MT_RDREQ;
               ob_addr = cpu_addr;
               st_n    = SQ_WAIT;
            end
         end
         SQ_WAIT: begin
            if (in_fire) begin
               if (reply_hit) begin
                  lw_en   = 1'b1;
                  lw_st   = cpu_we ? LS_EXC : LS_SHR;
                  lw_dat  = cpu_we ? cpu_wdata : in_data;
                  rd_load = 1'b1;
                  rd_n    = cpu_we ? cpu_wdata : in_data;
                  st_n    = SQ_ACK;
               end else begin
                  coh_go = 1'b1;
               end
            end
         end
         SQ_ACK:  st_n = SQ_IDLE;
         default: st_n = SQ_IDLE;
      endcase

      if (coh_go) begin
         case (in_msg)
            MT_INVAL: begin
               if (b_match && (rb_st == LS_SHR)) begin
                  lw_en  = 1'b1;
                  lw_idx = iidx;
                  lw_st  = LS_INV;
                  lw_tag = rb_tag;
                  lw_dat = rb_dat;
               end
            end
            MT_FETCH, MT_FETINV: begin
               if (b_match && (rb_st == LS_EXC)) begin
                  ob_load = 1'b1;
                  ob_type = MT_WBACK;
                  ob_addr = in_addr;
                  ob_data = rb_dat;
                  lw_en   = 1'b1;
                  lw_idx  = iidx;
                  lw_st   = (in_msg == MT_FETCH) ? LS_SHR : LS_INV;
                  lw_tag  = rb_tag;
                  lw_dat  = rb_dat;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= SQ_IDLE;
         rd_q <= '0;
      end else begin
         st_q <= st_n;
         if (rd_load) rd_q <= rd_n;
      end
   end

   assign cpu_ack   = (st_q == SQ_ACK);
   assign cpu_rdata = rd_q;

   // R2: completion lasts exactly one cycle
   p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);

   // R4: a matching reply during the wait completes the access next cycle
   p_reply_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == SQ_WAIT) && in_fire && reply_hit) |=> cpu_ack);

   // R4: no completion while the request is still being issued
   p_no_early_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_REQ) |=> !cpu_ack);

   // R7 R8: a fetch that hits an owned line produces an outgoing message
   p_fetch_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (coh_go && ((in_msg == MT_FETCH) || (in_msg == MT_FETINV))
       && b_match && (rb_st == LS_EXC)) |=> ob_valid);

   // R10: a command for an address not held leaves the outgoing port idle
   p_ignore_unheld_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (coh_go && !b_match && ((in_msg == MT_INVAL) || (in_msg == MT_FETCH)
                              || (in_msg == MT_FETINV))) |=> !ob_valid);

endmodule

// File: rtl/dir_node_cache.sv
module dir_node_cache
   import dnc_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int IDX_W   = 2,
   parameter int NODE_W  = 2,
   parameter int NODE_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [2:0]        out_type,
   output logic [NODE_W-1:0] out_src,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [2:0]        in_type,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data
);

   localparam int TAG_W = ADDR_W - IDX_W;

   initial begin
      assert (IDX_W >= 1 && IDX_W < ADDR_W)
         else $error("IDX_W must be at least 1 and below ADDR_W");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (NODE_W >= 1 && NODE_ID >= 0 && NODE_ID < (2 ** NODE_W))
         else $error("NODE_ID does not fit NODE_W");
   end

   logic              ob_load, ob_valid;
   msg_t              ob_type, mr_type;
   logic [ADDR_W-1:0] ob_addr;
   logic [DATA_W-1:0] ob_data;

   logic              lw_en;
   logic [IDX_W-1:0]  lw_idx, ra_idx, rb_idx;
   line_st_t          lw_st, ra_st, rb_st;
   logic [TAG_W-1:0]  lw_tag, ra_tag, rb_tag;
   logic [DATA_W-1:0] lw_dat, ra_dat, rb_dat;

   dnc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr),
      .in_data(in_data), .in_ready(in_ready),
      .ob_valid(ob_valid), .ob_load(ob_load), .ob_type(ob_type),
      .ob_addr(ob_addr), .ob_data(ob_data),
      .lw_en(lw_en), .lw_idx(lw_idx), .lw_st(lw_st), .lw_tag(lw_tag),
      .lw_dat(lw_dat),
      .ra_idx(ra_idx), .ra_st(ra_st), .ra_tag(ra_tag), .ra_dat(ra_dat),
      .rb_idx(rb_idx), .rb_st(rb_st), .rb_tag(rb_tag), .rb_dat(rb_dat)
   );

   dnc_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
      .clk(clk), .rst_n(rst_n),
      .wr_en(lw_en), .wr_idx(lw_idx), .wr_st(lw_st), .wr_tag(lw_tag),
      .wr_dat(lw_dat),
      .ra_idx(ra_idx), .ra_st(ra_st), .ra_tag(ra_tag), .ra_dat(ra_dat),
      .rb_idx(rb_idx), .rb_st(rb_st), .rb_tag(rb_tag), .rb_dat(rb_dat)
   );

   dnc_msg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .load(ob_load), .ld_type(ob_type), .ld_addr(ob_addr), .ld_data(ob_data),
      .out_ready(out_ready), .out_valid(ob_valid), .out_type(mr_type),
      .out_addr(out_addr), .out_data(out_data)
   );

   assign out_valid = ob_valid;
   assign out_type  = mr_type;
   assign out_src   = NODE_W'(NODE_ID);

   // R11: no incoming message is taken while an outgoing one waits
   p_block_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> !in_ready);

endmodule

// File: tb/dir_node_cache_test.sv
`timescale 1ns/1ps
module dir_node_cache_test;

   localparam int AW = 6;
   localparam int DW = 8;
   localparam int IW = 2;
   localparam int NW = 2;
   localparam int NID = 2;
   localparam int T1 = 4'h3;
   localparam int T2 = 4'hA;

   localparam int RDREQ = 0, WRREQ = 1, INVAL = 2, FETCH = 3, FETINV = 4,
                  REPLY = 5, WBACK = 6;

   logic clk = 1'b0;
   logic rst_n;
   logic cpu_req, cpu_we;
   logic [AW-1:0] cpu_addr;
   logic [DW-1:0] cpu_wdata;
   logic cpu_ack;
   logic [DW-1:0] cpu_rdata;
   logic out_valid, out_ready;
   logic [2:0] out_type;
   logic [NW-1:0] out_src;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_data;
   logic in_valid, in_ready;
   logic [2:0] in_type;
   logic [AW-1:0] in_addr;
   logic [DW-1:0] in_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dir_node_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .NODE_W(NW),
                    .NODE_ID(NID)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
      .out_src(out_src), .out_addr(out_addr), .out_data(out_data),
      .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
      .in_addr(in_addr), .in_data(in_data)
   );

   function automatic logic [AW-1:0] mk(int t, int i);
      return AW'((t << IW) | i);
   endfunction

   function automatic int rd_val(int t, int i);
      return (t * 16 + i * 7 + 1) & 8'hFF;
   endfunction

   function automatic int wr_val(int i);
      return (8'hC0 + i * 5) & 8'hFF;
   endfunction

   function automatic int wr2_val(int i);
      return (8'h50 + i * 9) & 8'hFF;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cpu_start(bit we, logic [AW-1:0] a, logic [DW-1:0] d);
      cpu_req = 1'b1;
      cpu_we = we;
      cpu_addr = a;
      cpu_wdata = d;
   endtask

   task automatic cpu_finish(string req, int exp);
      chk(cpu_ack == 1'b1, req, "ack", int'(cpu_ack), 1);
      chk(int'(cpu_rdata) == exp, req, "rdata", int'(cpu_rdata), exp);
      cpu_req = 1'b0;
      @(negedge clk);
      chk(cpu_ack == 1'b0, req, "ack drop", int'(cpu_ack), 0);
   endtask

   task automatic expect_out(string req, int typ, logic [AW-1:0] a, int d);
      int n = 0;
      logic [AW-1:0] a0;
      while (!out_valid && n < 30) begin
         @(negedge clk);
         n++;
      end
      chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
      chk(int'(out_type) == typ, req, "out_type", int'(out_type), typ);
      chk(out_addr == a, req, "out_addr", int'(out_addr), int'(a));
      chk(int'(out_src) == NID, req, "out_src", int'(out_src), NID);
      if (typ == WBACK)
         chk(int'(out_data) == d, req, "out_data", int'(out_data), d);
      chk(in_ready == 1'b0, "R11", "in_ready while pending", int'(in_ready), 0);
      a0 = out_addr;
      @(negedge clk);
      chk(out_valid && out_addr == a0 && int'(out_type) == typ, "R3",
          "held message", int'(out_addr), int'(a0));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic send_in(int typ, logic [AW-1:0] a, int d);
      int n = 0;
      in_valid = 1'b1;
      in_type = 3'(typ);
      in_addr = a;
      in_data = DW'(d);
      while (!in_ready && n < 30) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic quiet(string req, int cycles);
      for (int k = 0; k < cycles; k++) begin
         chk(out_valid == 1'b0, req, "no message", int'(out_valid), 0);
         @(negedge clk);
      end
   endtask

   task automatic read_miss(string req, logic [AW-1:0] a, int d);
      cpu_start(1'b0, a, '0);
      expect_out(req, RDREQ, a, 0);
      chk(cpu_ack == 1'b0, "R4", "stalled before reply", int'(cpu_ack), 0);
      send_in(REPLY, a, d);
      cpu_finish(req, d);
   endtask

   task automatic read_hit(string req, logic [AW-1:0] a, int d);
      cpu_start(1'b0, a, '0);
      @(negedge clk);
      chk(out_valid == 1'b0, req, "hit sends nothing", int'(out_valid), 0);
      cpu_finish(req, d);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      out_ready = 1'b0;
      in_valid = 1'b0; in_type = '0; in_addr = '0; in_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
      chk(cpu_ack == 1'b0, "R1", "cpu_ack", int'(cpu_ack), 0);
      chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);

      // R1 R3 R4: every index starts Invalid; read fills Shared; R2 hits
      for (int i = 0; i < 4; i++) begin
         read_miss("R1 R3 R4", mk(T1, i), rd_val(T1, i));
         read_hit("R2", mk(T1, i), rd_val(T1, i));
      end

      // R3 R4: write to Shared needs a write request; R5 then hits
      for (int i = 0; i < 4; i++) begin
         cpu_start(1'b1, mk(T1, i), DW'(wr_val(i)));
         expect_out("R3", WRREQ, mk(T1, i), 0);
         chk(cpu_ack == 1'b0, "R4", "stalled before reply", int'(cpu_ack), 0);
         send_in(REPLY, mk(T1, i), rd_val(T1, i));
         cpu_finish("R4", wr_val(i));
         read_hit("R4", mk(T1, i), wr_val(i));
         cpu_start(1'b1, mk(T1, i), DW'(wr2_val(i)));
         @(negedge clk);
         chk(out_valid == 1'b0, "R5", "write hit sends nothing", int'(out_valid), 0);
         cpu_finish("R5", wr2_val(i));
         read_hit("R5", mk(T1, i), wr2_val(i));
      end

      // R7: fetch of line 0 returns data and leaves it Shared
      send_in(FETCH, mk(T1, 0), 0);
      expect_out("R7", WBACK, mk(T1, 0), wr2_val(0));
      read_hit("R7", mk(T1, 0), wr2_val(0));
      cpu_start(1'b1, mk(T1, 0), DW'(8'h77));
      expect_out("R7", WRREQ, mk(T1, 0), 0);
      send_in(REPLY, mk(T1, 0), wr2_val(0));
      cpu_finish("R7", 8'h77);

      // R8: fetch-and-invalidate of line 1 drops the copy
      send_in(FETINV, mk(T1, 1), 0);
      expect_out("R8", WBACK, mk(T1, 1), wr2_val(1));
      read_miss("R8", mk(T1, 1), 8'h3C);

      // R10: commands for a tag not held change nothing
      send_in(INVAL, mk(T2, 2), 0);
      quiet("R10", 2);
      send_in(FETCH, mk(T2, 2), 0);
      quiet("R10", 2);
      send_in(FETINV, mk(T2, 2), 0);
      quiet("R10", 2);
      read_hit("R10", mk(T1, 2), wr2_val(2));

      // R6: invalidate of Shared line 1 forces a miss
      send_in(INVAL, mk(T1, 1), 0);
      quiet("R6", 1);
      read_miss("R6", mk(T1, 1), 8'h4D);

      // R9: Exclusive victims at lines 2 and 3 leave before the request
      for (int i = 2; i < 4; i++) begin
         cpu_start(1'b0, mk(T2, i), '0);
         expect_out("R9", WBACK, mk(T1, i), wr2_val(i));
         expect_out("R9", RDREQ, mk(T2, i), 0);
         send_in(REPLY, mk(T2, i), rd_val(T2, i));
         cpu_finish("R9", rd_val(T2, i));
         read_hit("R9", mk(T2, i), rd_val(T2, i));
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule